// File: doc/BRIEF.md
# ADC Control and Status Register

This block is the bus-facing control word of an analog-to-digital converter. It sits on a simple 8-bit register bus that has an address, a write strobe, a read strobe, write data and read data. The block holds three settings: an interrupt-enable bit, a continuous-conversion bit and a five-bit input channel select. It also tracks whether a conversion has finished. The converter itself is outside the block. It appears only as a one-cycle `conv_done` pulse. In the other direction, the block drives a one-cycle start strobe together with the selected channel.

The completion flag means different things depending on the interrupt-enable bit:

- With interrupts off, the flag is the polled completion indication.
- With interrupts on, a completion raises a level interrupt request instead, and the flag stays at zero. Zero is the encoding that selects a processor interrupt rather than a transfer-engine request.

Both the flag and the pending interrupt clear as a side effect of either of two accesses:

- any write to this register;
- a read of the converter's data register, which lives at a second address.

Top module: `adc_ctl_status_reg`

## Requirements
- R1: After reset, reading the register address (default 0) returns 8'h1F: flag, enable and continuous bits at 0 and the channel field all ones. `irq` and `conv_start` are 0 after reset.
- R2: The register word is {flag[7], enable[6], continuous[5], channel[4:0]}. A write stores bits 6..0, which read back and also appear on `conv_cont` and `conv_chan`. The written bit 7 never sets the flag.
- R3: While enable is 0, a `conv_done` pulse sets bit 7 from the next cycle onward, and `irq` stays 0.
- R4: The flag is cleared by any write to the register, and by a read strobe at the data-register address (default 1). A read of the register address itself leaves the flag unchanged.
- R5: While enable is 1, a `conv_done` pulse raises `irq` from the next cycle onward, and the flag stays 0.
- R6: Once raised, `irq` stays high until a register write or a data-register read clears it.
- R7: When `conv_done` arrives in the same cycle as a clearing access, the done pulse wins. Whether the flag or `irq` is set then depends on the enable value in force after that cycle.
- R8: A write that clears the enable bit drops `irq` in the following cycle. `irq` is never high while enable is 0.
- R9: Every register write makes `conv_start` high for exactly one cycle, the cycle after the write, with the new channel already on `conv_chan`. `conv_start` is 0 at all other times.
- R10: Reads of any address other than the register return 0. Writes to any other address change nothing and start no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational by default) |
| conv_done | input | 1 | One-cycle conversion-finished pulse from the converter |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 5 | Selected input channel |
| conv_cont | output | 1 | Continuous-conversion setting |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that the reset is applied before the first conversion pulse. They also assume that `conv_done` and both strobes are clean single-cycle levels sampled at the clock edge. The done-wins property relies on the enable bit changing only through a register write.

The random stimulus respects these assumptions:

- it drives every input half a cycle away from the active edge;
- it holds reset until the inputs are idle;
- it keeps the address within a small range, so that register writes, data reads, stray accesses and done pulses collide often.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;
   localparam int unsigned CHAN_W   = 5;
   localparam int unsigned WORD_W   = CHAN_W + 3;
   localparam int unsigned FLAG_BIT = WORD_W - 1;
   localparam int unsigned IEN_BIT  = WORD_W - 2;
   localparam int unsigned CONT_BIT = WORD_W - 3;

   typedef struct packed {
      logic              done_flag;
      logic              irq_en;
      logic              cont;
      logic [CHAN_W-1:0] chan;
   } csr_word_t;
endpackage

// File: rtl/adc_csr_decode.sv
module adc_csr_decode #(
   parameter int unsigned       ADDR_W    = 3,
   parameter logic [ADDR_W-1:0] CSR_ADDR  = '0,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              csr_sel,
   output logic              csr_wr,
   output logic              data_rd
);
   initial begin
      assert (CSR_ADDR != DATA_ADDR)
         else $error("register and data addresses must differ");
   end

   always_comb begin
      csr_sel = (addr == CSR_ADDR);
      csr_wr  = wr & csr_sel;
      data_rd = rd & (addr == DATA_ADDR);
   end
endmodule

// File: rtl/adc_csr_fields.sv
module adc_csr_fields import adc_csr_pkg::*; #(
   parameter logic [CHAN_W-1:0] CHAN_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [WORD_W-2:0] wdata,
   output logic              ien_q,
   output logic              ien_next,
   output logic              cont_q,
   output logic [CHAN_W-1:0] chan_q,
   output logic              start_q
);
   always_comb begin
      ien_next = csr_wr ? wdata[IEN_BIT] : ien_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q   <= 1'b0;
         cont_q  <= 1'b0;
         chan_q  <= CHAN_RST;
         start_q <= 1'b0;
      end else begin
         start_q <= csr_wr;
         if (csr_wr) begin
            ien_q  <= wdata[IEN_BIT];
            cont_q <= wdata[CONT_BIT];
            chan_q <= wdata[CHAN_W-1:0];
         end
      end
   end
endmodule

// File: rtl/adc_csr_flags.sv
module adc_csr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic clr,
   input  logic ien_q,
   input  logic ien_next,
   output logic flag_q,
   output logic irq
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (done && !ien_next)
            flag_q <= 1'b1;
         else if (clr)
            flag_q <= 1'b0;

         if (done && ien_next)
            pend_q <= 1'b1;
         else if (clr)
            pend_q <= 1'b0;
      end
   end

   assign irq = pend_q & ien_q;
endmodule

// File: rtl/adc_ctl_status_reg.sv
module adc_ctl_status_reg import adc_csr_pkg::*; #(
   parameter int unsigned       ADDR_W    = 3,
   parameter logic [ADDR_W-1:0] CSR_ADDR  = '0,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 1,
   parameter logic [CHAN_W-1:0] CHAN_RST  = '1,
   parameter bit                READ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              conv_done,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   output logic              conv_cont,
   output logic              irq
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 16) else $error("ADDR_W out of range");
      assert (WORD_W == 8) else $error("register word must be 8 bits");
   end

   logic              csr_sel, csr_wr, data_rd;
   logic              ien_q, ien_next, cont_q, start_q, flag_q;
   logic [CHAN_W-1:0] chan_q;
   csr_word_t         word;
   logic              unused_wbit;

   assign unused_wbit = bus_wdata[FLAG_BIT];

   adc_csr_decode #(
      .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_dec (
      .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .csr_sel(csr_sel), .csr_wr(csr_wr), .data_rd(data_rd)
   );

   adc_csr_fields #(.CHAN_RST(CHAN_RST)) u_fld (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr),
      .wdata(bus_wdata[WORD_W-2:0]),
      .ien_q(ien_q), .ien_next(ien_next), .cont_q(cont_q),
      .chan_q(chan_q), .start_q(start_q)
   );

   adc_csr_flags u_flg (
      .clk(clk), .rst_n(rst_n), .done(conv_done),
      .clr(csr_wr | data_rd), .ien_q(ien_q), .ien_next(ien_next),
      .flag_q(flag_q), .irq(irq)
   );

   always_comb begin
      word.done_flag = flag_q;
      word.irq_en    = ien_q;
      word.cont      = cont_q;
      word.chan      = chan_q;
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [WORD_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rdata_q <= '0;
            else if (bus_rd)
               rdata_q <= csr_sel ? word : '0;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = csr_sel ? word : '0;
      end
   endgenerate

   assign conv_start = start_q;
   assign conv_chan  = chan_q;
   assign conv_cont  = cont_q;
endmodule

// File: rtl/adc_csr_chk.sv
module adc_csr_chk (
   input logic clk,
   input logic rst_n,
   input logic csr_wr,
   input logic data_rd,
   input logic conv_done,
   input logic flag_q,
   input logic ien_q,
   input logic irq,
   input logic conv_start
);
   // R5
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ien_q |-> !flag_q);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_q |-> !irq);

   // R9
   start_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr |=> conv_start);

   // R9
   start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_wr |=> !conv_start);

   // R4
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr || data_rd) && !conv_done |=> !flag_q && !irq);

   // R7
   done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done && !csr_wr |=> (flag_q || irq));

   // R6
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !csr_wr && !data_rd |=> irq);
endmodule

bind adc_ctl_status_reg adc_csr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .data_rd(data_rd),
   .conv_done(conv_done), .flag_q(flag_q), .ien_q(ien_q),
   .irq(irq), .conv_start(conv_start)
);

// File: tb/sim_adc_ctl_status_reg.sv
module sim_adc_ctl_status_reg;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] A_CSR  = 3'd0;
   localparam logic [2:0] A_DATA = 3'd1;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] bus_addr;
   logic       bus_wr, bus_rd, conv_done;
   logic [7:0] bus_wdata, bus_rdata;
   logic       conv_start, conv_cont, irq;
   logic [4:0] conv_chan;

   int n_chk = 0;
   int n_bad = 0;

   logic       m_flag, m_ien, m_cont, m_pend, m_start;
   logic [4:0] m_chan;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_ctl_status_reg u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
      .conv_cont(conv_cont), .irq(irq)
   );

   function automatic logic [7:0] exp_word();
      return {m_flag, m_ien, m_cont, m_chan};
   endfunction

   function automatic logic [7:0] exp_rdata(input logic [2:0] a);
      return (a == A_CSR) ? exp_word() : 8'h00;
   endfunction

   task automatic chk(input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "irq", int'(irq), int'(m_pend & m_ien));
      chk(tag, "conv_start", int'(conv_start), int'(m_start));
      chk(tag, "conv_chan", int'(conv_chan), int'(m_chan));
      chk(tag, "conv_cont", int'(conv_cont), int'(m_cont));
      chk(tag, "rdata", int'(bus_rdata), int'(exp_rdata(bus_addr)));
   endtask

   task automatic cyc(input string tag, input logic wr, input logic rd,
                      input logic [2:0] a, input logic [7:0] wd,
                      input logic dn);
      logic cw, dr, ien_n;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; conv_done = dn;
      @(posedge clk);
      cw    = wr && (a == A_CSR);
      dr    = rd && (a == A_DATA);
      ien_n = cw ? wd[6] : m_ien;
      if (dn && !ien_n)   m_flag = 1'b1;
      else if (cw || dr)  m_flag = 1'b0;
      if (dn && ien_n)    m_pend = 1'b1;
      else if (cw || dr)  m_pend = 1'b0;
      m_start = cw;
      if (cw) begin
         m_ien = wd[6]; m_cont = wd[5]; m_chan = wd[4:0];
      end
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic idle(input string tag);
      cyc(tag, 1'b0, 1'b0, A_CSR, 8'h00, 1'b0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = A_CSR;
      bus_wdata = 8'h00; conv_done = 1'b0;
      m_flag = 0; m_ien = 0; m_cont = 0; m_pend = 0; m_start = 0; m_chan = 5'h1F;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, literal values
      chk("R1", "rdata", int'(bus_rdata), 'h1F);
      chk("R1", "irq", int'(irq), 0);
      chk("R1", "conv_start", int'(conv_start), 0);
      idle("R1");

      // R3 polled completion
      cyc("R3", 0, 0, A_CSR, 8'h00, 1'b1);
      chk("R3", "flag bit", int'(bus_rdata[7]), 1);
      idle("R3");
      // R4 register read keeps flag, data read clears
      cyc("R4", 0, 1, A_CSR, 8'h00, 1'b0);
      chk("R4", "flag after csr read", int'(bus_rdata[7]), 1);
      cyc("R4", 0, 1, A_DATA, 8'h00, 1'b0);
      idle("R4");
      chk("R4", "flag after data read", int'(bus_rdata[7]), 0);
      // R2 write of bit 7 ignored, fields stored
      cyc("R2", 0, 0, A_CSR, 8'h00, 1'b1);
      cyc("R2", 1, 0, A_CSR, 8'hA5, 1'b0);
      chk("R2", "rdata", int'(bus_rdata), 'h25);
      // R9 start strobe one cycle wide
      chk("R9", "conv_start", int'(conv_start), 1);
      idle("R9");
      chk("R9", "conv_start low", int'(conv_start), 0);

      // R5 interrupt mode
      cyc("R5", 1, 0, A_CSR, 8'h43, 1'b0);
      cyc("R5", 0, 0, A_CSR, 8'h00, 1'b1);
      chk("R5", "irq", int'(irq), 1);
      chk("R5", "flag bit", int'(bus_rdata[7]), 0);
      // R6 level holds then clears
      idle("R6"); idle("R6");
      chk("R6", "irq held", int'(irq), 1);
      cyc("R6", 0, 1, A_DATA, 8'h00, 1'b0);
      chk("R6", "irq cleared", int'(irq), 0);
      // R7 done wins over clearing access
      cyc("R7", 0, 0, A_CSR, 8'h00, 1'b1);
      cyc("R7", 0, 1, A_DATA, 8'h00, 1'b1);
      chk("R7", "irq kept", int'(irq), 1);
      cyc("R7", 1, 0, A_CSR, 8'h07, 1'b1);
      chk("R7", "flag set on write", int'(bus_rdata[7]), 1);
      // R8 dropping enable drops irq
      cyc("R8", 1, 0, A_CSR, 8'h41, 1'b0);
      cyc("R8", 0, 0, A_CSR, 8'h00, 1'b1);
      cyc("R8", 1, 0, A_CSR, 8'h01, 1'b0);
      chk("R8", "irq", int'(irq), 0);
      // R10 other addresses
      cyc("R10", 1, 0, 3'd2, 8'h7E, 1'b0);
      chk("R10", "no start", int'(conv_start), 0);
      cyc("R10", 0, 1, 3'd5, 8'h00, 1'b0);
      chk("R10", "stray read", int'(bus_rdata), 0);
      idle("R10");
      chk("R10", "state kept", int'(bus_rdata), 'h01);

      // random mix covering R2 R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < 3000; i++) begin
         cyc("random", ($urandom_range(0, 5) == 0), ($urandom_range(0, 3) == 0),
             3'($urandom_range(0, 3)), 8'($urandom),
             ($urandom_range(0, 6) == 0));
      end
      finish_run();
   end
endmodule